// File: doc/BRIEF.md
# Option-Configured Watchdog Timer

This block is a watchdog timer whose start-up behaviour is fixed by a static option byte held in non-volatile storage. While the power-up reset is low, the block decodes three fields of that byte: an active-low hardware-start bit, an idle-run bit and a 3-bit prescaler code. When the hardware-start bit is 0, the idle-run bit and the prescaler code go into the run-time control register with its enable bit set. Counting then begins on the first clock after reset release, with no software action. A watchdog started this way stays locked on until the next power-up reset.

During operation, a prescaler divides the clock by a power of two, and a counter of `CNT_W` bits (15 by default) advances once per prescaler tick. When the counter overflows, the block raises a one-cycle reset request and the counter wraps to zero. Software restarts the count with a clear strobe. Software can also rewrite the control register through a write strobe, and reads it back on a dedicated output. The CPU idle input freezes counting unless the idle-run setting is 1.

Top module: `wdt_optcfg`

## Requirements
- R1: When option bit 5 is 0, after reset the control readback `ctl_rdata` (bit 4 enable, bit 3 idle-run, bits 2:0 prescaler code) equals {1, option bit 3, option bits 2:0}.
- R2: When option bit 5 is 1, after reset `ctl_rdata` is 0 whatever the other option bits are, and no reset request is issued.
- R3: With prescaler code n, the counter advances once per 2^(n+1) active clocks, so the first reset request comes 2^(n+1)·2^CNT_W active clocks after counting starts.
- R4: On overflow, `wdt_rst_req` is high for exactly one clock and the count wraps to 0, so the following request comes one full period later.
- R5: With idle-run 0, clocks with `cpu_idle` high do not advance the prescaler or the counter.
- R6: With idle-run 1, `cpu_idle` has no effect on the timing of reset requests.
- R7: A `sw_clear` pulse returns the prescaler and the counter to 0, so the next request comes a full period after the clear.
- R8: A `sw_clear` that lands on the overflow clock wins: no reset request is issued in that cycle.
- R9: After a hardware start, a control write with enable 0 leaves enable at 1 and updates the other fields.
- R10: Without a hardware start, software can set enable to start counting and clear it to stop counting; with enable 0 no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low synchronous power-up reset; the option byte is sampled while it is low |
| opt_byte | input | 8 | Static option byte: bit 5 hardware start (active low), bit 3 idle-run, bits 2:0 prescaler code |
| cpu_idle | input | 1 | High while the CPU is in idle mode |
| sw_clear | input | 1 | Software clear strobe: restarts prescaler and counter |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data: bit 4 enable, bit 3 idle-run, bits 2:0 prescaler code |
| ctl_rdata | output | 5 | Control register readback, same layout |
| wdt_rst_req | output | 1 | One-cycle reset request on counter overflow |

## Verification
Errors in the hidden prescaler or counter state cannot be seen directly; they show up only as a shift in the exact clock of a reset-request pulse. The bench therefore predicts the exact cycle of every pulse and catches an error in the first period after it occurs. A wrong decode of the option byte or a broken lock appears on `ctl_rdata` one clock after reset release or after a write. A clear or idle freeze that fails shifts the next pulse by a known number of cycles, and a pulse that arrives when none is expected is reported at once.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // option byte bit positions, fixed by the storage layout
   localparam int OPT_W          = 8;
   localparam int OPT_HWSTART_N  = 5;
   localparam int OPT_IDLE_RUN   = 3;
   localparam int OPT_PS_LSB     = 0;

   localparam int PS_CODE_W      = 3;

   typedef struct packed {
      logic                 en;
      logic                 idle_run;
      logic [PS_CODE_W-1:0] ps;
   } wdt_ctl_t;

   localparam int CTL_W = $bits(wdt_ctl_t);

endpackage

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
   import wdt_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 opt_hwstart_n,
   input  logic                 opt_idle_run,
   input  logic [PS_CODE_W-1:0] opt_ps,
   input  logic                 we,
   input  logic [CTL_W-1:0]     wdata,
   output wdt_ctl_t             ctl_q,
   output logic                 locked_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q <= !opt_hwstart_n;
         if (!opt_hwstart_n) begin
            ctl_q.en       <= 1'b1;
            ctl_q.idle_run <= opt_idle_run;
            ctl_q.ps       <= opt_ps;
         end else begin
            ctl_q <= '0;
         end
      end else if (we) begin
         ctl_q <= wdt_ctl_t'(wdata);
         if (locked_q) ctl_q.en <= 1'b1;
      end
   end

   // R9
   lock_holds_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |-> ctl_q.en);

   // R9
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q);

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              active,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);

   localparam int NCODES = 1 << CODE_W;
   localparam int PRE_W  = NCODES;          // code n needs n+1 bits

   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code_w
      $error("wdt_prescaler: CODE_W must lie in 1..4");
   end

   logic [PRE_W-1:0] mask_tbl [NCODES];
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;
   logic             at_end;

   for (genvar i = 0; i < NCODES; i++) begin : g_mask
      assign mask_tbl[i] = PRE_W'((64'd1 << (i + 1)) - 64'd1);
   end

   assign mask   = mask_tbl[code];
   assign at_end = (pre_q >= mask);
   assign tick   = en && active && !clr && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || clr || !en) begin
         pre_q <= '0;
      end else if (active) begin
         pre_q <= at_end ? '0 : pre_q + 1'b1;
      end
   end

   // R7
   pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pre_q == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic             req_q
);

   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt_w
      $error("wdt_counter: CNT_W must lie in 2..31");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr || !en) begin
         cnt_q <= '0;
         req_q <= 1'b0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
         req_q <= &cnt_q;
      end else begin
         req_q <= 1'b0;
      end
   end

   // R4
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q);

   // R4
   req_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> (cnt_q == '0));

   // R8
   clear_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!req_q && cnt_q == '0));

endmodule

// File: rtl/wdt_optcfg.sv
module wdt_optcfg
   import wdt_pkg::*;
#(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPT_W-1:0] opt_byte,
   input  logic             cpu_idle,
   input  logic             sw_clear,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   output logic             wdt_rst_req
);

   wdt_ctl_t         ctl;
   logic             locked;
   logic             active;
   logic             tick;
   logic [CNT_W-1:0] cnt;

   wdt_ctl_reg u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .opt_hwstart_n (opt_byte[OPT_HWSTART_N]),
      .opt_idle_run  (opt_byte[OPT_IDLE_RUN]),
      .opt_ps        (opt_byte[OPT_PS_LSB +: PS_CODE_W]),
      .we            (ctl_we),
      .wdata         (ctl_wdata),
      .ctl_q         (ctl),
      .locked_q      (locked)
   );

   assign active = ctl.en && (!cpu_idle || ctl.idle_run);

   wdt_prescaler #(.CODE_W(PS_CODE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sw_clear),
      .en     (ctl.en),
      .active (active),
      .code   (ctl.ps),
      .tick   (tick)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sw_clear),
      .en    (ctl.en),
      .tick  (tick),
      .cnt_q (cnt),
      .req_q (wdt_rst_req)
   );

   assign ctl_rdata = ctl;

   // R5
   idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.en && cpu_idle && !ctl.idle_run && !sw_clear && !ctl_we)
         |=> $stable(cnt));

   // R10
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.en && !ctl_we) |=> (!wdt_rst_req && cnt == '0));

   // R9
   reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(opt_byte) |-> (locked == !opt_byte[OPT_HWSTART_N]));

endmodule

// File: tb/tb_wdt_optcfg.sv
module tb_wdt_optcfg;

   localparam int CW = 4;   // short counter keeps periods small

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opt_byte = 8'hFF;
   logic       cpu_idle = 1'b0;
   logic       sw_clear = 1'b0;
   logic       ctl_we = 1'b0;
   logic [4:0] ctl_wdata = '0;
   logic [4:0] ctl_rdata;
   logic       wdt_rst_req;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int s = 0;
   int exp_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdt_optcfg #(.CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .opt_byte(opt_byte), .cpu_idle(cpu_idle),
      .sw_clear(sw_clear), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .wdt_rst_req(wdt_rst_req)
   );

   task automatic check(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the expected pulse cycle and compares
   always @(negedge clk) begin
      if (rst_n && wdt_rst_req) begin
         if (exp_q.size() == 0) check("R4/R8/R10 unexpected request at cycle", cyc, -1);
         else check("R3/R4 request cycle", cyc, exp_q.pop_front());
      end
   end

   task automatic finish_case(input string tag);
      check({tag, " pending requests"}, exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic start(input logic [7:0] opt);
      rst_n = 1'b0; opt_byte = opt; cpu_idle = 0; sw_clear = 0; ctl_we = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      s = cyc;
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic write_ctl(input logic [4:0] d);
      ctl_wdata = d; ctl_we = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   initial begin
      // R2: erased option byte, no start
      start(8'hFF);
      check("R2 readback erased", ctl_rdata, 0);
      wait_to(s + 80);
      finish_case("R2");
      // R2: fields ignored when start bit is 1
      start(8'hEA);
      check("R2 fields ignored", ctl_rdata, 0);
      // R1: hardware start decode
      start(8'hDF);
      check("R1 readback", ctl_rdata, 5'b11111);
      start(8'hD0);
      check("R1 readback idle0", ctl_rdata, 5'b10000);

      // R3 R4 R6: code 0, idle held high, idle-run 1
      start(8'hD8);
      cpu_idle = 1'b1;
      exp_q.push_back(s + 32); exp_q.push_back(s + 64);
      wait_to(s + 70);
      finish_case("R6");

      // R3: code 2 divides by 8
      start(8'hDA);
      exp_q.push_back(s + 128);
      wait_to(s + 135);
      finish_case("R3");

      // R5: idle-run 0, 10 idle clocks delay the request
      start(8'hD0);
      cpu_idle = 1'b1;
      exp_q.push_back(s + 42);
      repeat (10) @(negedge clk);
      cpu_idle = 1'b0;
      wait_to(s + 50);
      finish_case("R5");

      // R7 R8: clear mid-count and on the overflow clock
      start(8'hD8);
      exp_q.push_back(s + 52); exp_q.push_back(s + 116);
      wait_to(s + 19);
      sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
      wait_to(s + 83);
      sw_clear = 1'b1; @(negedge clk); sw_clear = 1'b0;
      wait_to(s + 120);
      finish_case("R7/R8");

      // R9: lock keeps enable
      start(8'hD8);
      write_ctl(5'b00010);
      check("R9 lock keeps enable", ctl_rdata, 5'b10010);
      start(8'hFF);

      // R10: software start and stop
      exp_q.push_back(s + 33);
      write_ctl(5'b11000);
      check("R10 sw enable readback", ctl_rdata, 5'b11000);
      wait_to(s + 40);
      finish_case("R10 start");
      write_ctl(5'b01000);
      check("R10 sw disable readback", ctl_rdata, 5'b01000);
      wait_to(s + 140);
      finish_case("R10 stop");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule